// File: doc/BRIEF.md
# Exception Status and Cause Register File

This block holds the four system-control registers that a 32-bit processor core consults when it takes an exception or an interrupt. The registers are a processor-state word, a cause word, the saved return address and the faulting data address. The core pulses an exception strobe with a 4-bit reason code, the already-advanced program counter and the address of the failing memory reference. The block then saves the return point, records the reason, and pushes the mode/enable history so that the handler runs in kernel mode with interrupts off. A return strobe pops that history again.

The state word keeps an 8-bit interrupt mask and a three-deep stack of mode/enable pairs. Five hardware interrupt lines are sampled into pending bits of the cause word whether or not they are masked. A single request output tells the core when an enabled, unmasked line is pending. A simple indexed port lets privileged code read all four registers and rewrite the state word and the return address.

Top module: `sysctl_exc_regs`

## Requirements
- R1: While reset is asserted, and after it is released, all four registers read zero, `kernel_mode` is 1, `int_enabled` is 0 and `irq_req` is 0.
- R2: A write with `reg_addr`=0 stores `reg_wdata[15:8]` as the mask and `reg_wdata[5:0]` as the mode stack. All other bits of the state word read as zero.
- R3: An exception moves state bits [3:0] into [5:2] and clears bits [1:0] (kernel mode, interrupts off) on the next clock edge.
- R4: A return strobe copies state bits [5:2] into [3:0] and leaves bits [5:4] unchanged.
- R5: An exception loads `exc_code` into cause bits [5:2] (0 interrupt, 4 load/fetch address error, 5 store address error, 6/7 instruction/data bus error, 8 system call, 9 breakpoint, 10 reserved opcode, 12 overflow). Cause bits [1:0], [9:6] and [31:16] read zero.
- R6: An exception loads the saved-address register (`reg_addr`=2) with `fault_pc` minus `PC_ADJ`, which points at the faulting instruction. Software can rewrite this register at index 2.
- R7: The bad-address register (`reg_addr`=3) takes `fault_addr` only on exceptions with code 4 or 5, and holds its value otherwise. Writes to index 3 have no effect.
- R8: Cause bit 10+i equals `hw_irq[i]` as sampled at the previous clock edge, independent of the mask. Writes to the cause word (index 1) have no effect.
- R9: `irq_req` is 1 exactly when some pending bit 10+i and state mask bit 10+i are both 1 and state bit 0 is 1.
- R10: An exception in the same cycle as a return or a register write takes effect alone, and the return and the write are dropped. A return in the same cycle as a state-word write takes effect, and the write is dropped.
- R11: `kernel_mode` is the inverse of state bit 1, and `int_enabled` equals state bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| exc_valid | input | 1 | Exception strobe |
| exc_code | input | 4 | Exception reason code |
| fault_pc | input | 32 | Program counter after increment at the faulting instruction |
| fault_addr | input | 32 | Memory address of the failing reference |
| hw_irq | input | 5 | Hardware interrupt lines |
| rfe | input | 1 | Return-from-exception strobe |
| reg_wr_en | input | 1 | Register write enable |
| reg_addr | input | 2 | Register index: 0 state, 1 cause, 2 saved address, 3 bad address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| irq_req | output | 1 | Masked interrupt request |
| kernel_mode | output | 1 | Current pair is in kernel mode |
| int_enabled | output | 1 | Current pair has interrupts enabled |

## Verification
The bench builds the block with its defaults: 32-bit addresses, five hardware lines, three stack levels and a program-counter adjustment of 4. With five lines, every pending bit and the unused mask bits (15, 9, 8) can be exercised against the request output. With three levels, two nested exceptions followed by two returns walk the stack through every shift, including the old pair being kept on return. An adjustment of 4 makes the saved address visibly differ from the supplied program counter.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int CODE_W      = 4;
  localparam int MASK_W      = 8;
  localparam int MASK_LO     = 8;
  localparam int PEND_LO     = 10;
  localparam int CODE_LO     = 2;
  localparam int IDX_W       = 2;

  typedef enum logic [IDX_W-1:0] {
    RSEL_STATE = 2'd0,
    RSEL_CAUSE = 2'd1,
    RSEL_EPC   = 2'd2,
    RSEL_BADVA = 2'd3
  } rsel_e;

  typedef enum logic [CODE_W-1:0] {
    XC_IRQ     = 4'd0,
    XC_ADDR_LD = 4'd4,
    XC_ADDR_ST = 4'd5,
    XC_IBUS    = 4'd6,
    XC_DBUS    = 4'd7,
    XC_SYSCALL = 4'd8,
    XC_BREAK   = 4'd9,
    XC_RESV    = 4'd10,
    XC_OVF     = 4'd12
  } xcode_e;

  typedef enum logic [1:0] {
    STK_HOLD = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2,
    STK_LOAD = 2'd3
  } stk_op_e;

  function automatic logic is_addr_fault(input logic [CODE_W-1:0] c);
    return (xcode_e'(c) == XC_ADDR_LD) || (xcode_e'(c) == XC_ADDR_ST);
  endfunction

endpackage

// File: rtl/exc_mode_stack.sv
module exc_mode_stack
  import sysctl_pkg::*;
#(
  parameter int LEVELS = 3,
  parameter int MSK_W  = 8,
  localparam int STK_W = 2 * LEVELS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  stk_op_e          op,
  input  logic [MSK_W-1:0] wr_mask,
  input  logic [STK_W-1:0] wr_stk,
  output logic [MSK_W-1:0] mask_q,
  output logic [STK_W-1:0] stk_q
);

  logic [MSK_W-1:0] mask_d;
  logic [STK_W-1:0] stk_d;
  logic             upd;

  always_comb begin
    mask_d = mask_q;
    stk_d  = stk_q;
    upd    = 1'b0;
    unique case (op)
      STK_PUSH: begin
        stk_d = {stk_q[STK_W-3:0], 2'b00};
        upd   = 1'b1;
      end
      STK_POP: begin
        stk_d = {stk_q[STK_W-1 -: 2], stk_q[STK_W-1:2]};
        upd   = 1'b1;
      end
      STK_LOAD: begin
        mask_d = wr_mask;
        stk_d  = wr_stk;
        upd    = 1'b1;
      end
      default: upd = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      stk_q  <= '0;
    end else if (upd) begin
      mask_q <= mask_d;
      stk_q  <= stk_d;
    end
  end

endmodule

// File: rtl/irq_cause_unit.sv
module irq_cause_unit
  import sysctl_pkg::*;
#(
  parameter int NUM_HW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_HW-1:0] hw_irq,
  input  logic              code_we,
  input  logic [CODE_W-1:0] code_in,
  output logic [NUM_HW-1:0] pend_q,
  output logic [CODE_W-1:0] code_q
);

  logic [NUM_HW-1:0] pend_d;
  logic [CODE_W-1:0] code_d;

  always_comb begin
    pend_d = hw_irq;
    code_d = code_we ? code_in : code_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else if (code_we) begin
      code_q <= code_d;
    end
  end

endmodule

// File: rtl/exc_addr_regs.sv
module exc_addr_regs #(
  parameter int XLEN   = 32,
  parameter int PC_ADJ = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exc_valid,
  input  logic            addr_fault,
  input  logic [XLEN-1:0] fault_pc,
  input  logic [XLEN-1:0] fault_addr,
  input  logic            epc_sw_we,
  input  logic [XLEN-1:0] sw_data,
  output logic [XLEN-1:0] epc_q,
  output logic [XLEN-1:0] badva_q
);

  logic [XLEN-1:0] epc_d;
  logic            epc_en;
  logic            badva_en;

  always_comb begin
    epc_en   = exc_valid | epc_sw_we;
    epc_d    = exc_valid ? (fault_pc - XLEN'(PC_ADJ)) : sw_data;
    badva_en = exc_valid & addr_fault;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_q <= '0;
    end else if (epc_en) begin
      epc_q <= epc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      badva_q <= '0;
    end else if (badva_en) begin
      badva_q <= fault_addr;
    end
  end

endmodule

// File: rtl/sysctl_exc_regs.sv
module sysctl_exc_regs
  import sysctl_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int NUM_HW = 5,
  parameter int LEVELS = 3,
  parameter int PC_ADJ = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_valid,
  input  logic [CODE_W-1:0] exc_code,
  input  logic [XLEN-1:0]   fault_pc,
  input  logic [XLEN-1:0]   fault_addr,
  input  logic [NUM_HW-1:0] hw_irq,
  input  logic              rfe,
  input  logic              reg_wr_en,
  input  logic [IDX_W-1:0]  reg_addr,
  input  logic [XLEN-1:0]   reg_wdata,
  output logic [XLEN-1:0]   reg_rdata,
  output logic              irq_req,
  output logic              kernel_mode,
  output logic              int_enabled
);

  localparam int STK_W   = 2 * LEVELS;
  localparam int HWM_OFS = PEND_LO - MASK_LO;

  logic              rst_meta;
  logic              rst_n_sync;
  stk_op_e           stk_op;
  logic [MASK_W-1:0] mask_q;
  logic [STK_W-1:0]  stk_q;
  logic [NUM_HW-1:0] pend_q;
  logic [CODE_W-1:0] code_q;
  logic [XLEN-1:0]   epc_q;
  logic [XLEN-1:0]   badva_q;
  logic              state_sw_we;
  logic              epc_sw_we;
  logic [NUM_HW-1:0] hw_mask;
  logic [XLEN-1:0]   state_word;
  logic [XLEN-1:0]   cause_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_n_sync <= rst_meta;
    end
  end

  always_comb begin
    state_sw_we = reg_wr_en & (rsel_e'(reg_addr) == RSEL_STATE);
    epc_sw_we   = reg_wr_en & (rsel_e'(reg_addr) == RSEL_EPC) & ~exc_valid;
    if (exc_valid)        stk_op = STK_PUSH;
    else if (rfe)         stk_op = STK_POP;
    else if (state_sw_we) stk_op = STK_LOAD;
    else                  stk_op = STK_HOLD;
  end

  exc_mode_stack #(
    .LEVELS (LEVELS),
    .MSK_W  (MASK_W)
  ) i_stack (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .op      (stk_op),
    .wr_mask (reg_wdata[MASK_LO +: MASK_W]),
    .wr_stk  (reg_wdata[STK_W-1:0]),
    .mask_q  (mask_q),
    .stk_q   (stk_q)
  );

  irq_cause_unit #(
    .NUM_HW (NUM_HW)
  ) i_cause (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .hw_irq  (hw_irq),
    .code_we (exc_valid),
    .code_in (exc_code),
    .pend_q  (pend_q),
    .code_q  (code_q)
  );

  exc_addr_regs #(
    .XLEN   (XLEN),
    .PC_ADJ (PC_ADJ)
  ) i_addr (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .exc_valid  (exc_valid),
    .addr_fault (is_addr_fault(exc_code)),
    .fault_pc   (fault_pc),
    .fault_addr (fault_addr),
    .epc_sw_we  (epc_sw_we),
    .sw_data    (reg_wdata),
    .epc_q      (epc_q),
    .badva_q    (badva_q)
  );

  always_comb begin
    hw_mask = mask_q[HWM_OFS +: NUM_HW];
    irq_req     = (|(pend_q & hw_mask)) & stk_q[0];
    int_enabled = stk_q[0];
    kernel_mode = ~stk_q[1];
  end

  always_comb begin
    state_word                   = '0;
    state_word[MASK_LO +: MASK_W] = mask_q;
    state_word[STK_W-1:0]        = stk_q;
    cause_word                   = '0;
    cause_word[PEND_LO +: NUM_HW] = pend_q;
    cause_word[CODE_LO +: CODE_W] = code_q;
  end

  always_comb begin
    unique case (rsel_e'(reg_addr))
      RSEL_STATE: reg_rdata = state_word;
      RSEL_CAUSE: reg_rdata = cause_word;
      RSEL_EPC:   reg_rdata = epc_q;
      default:    reg_rdata = badva_q;
    endcase
  end

endmodule

// File: rtl/sysctl_exc_regs_chk.sv
module sysctl_exc_regs_chk
  import sysctl_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int NUM_HW = 5,
  parameter int STK_W  = 6,
  parameter int PC_ADJ = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              exc_valid,
  input logic [CODE_W-1:0] exc_code,
  input logic [XLEN-1:0]   fault_pc,
  input logic              rfe,
  input logic [NUM_HW-1:0] hw_irq,
  input logic [STK_W-1:0]  stk_q,
  input logic [NUM_HW-1:0] pend_q,
  input logic [CODE_W-1:0] code_q,
  input logic [XLEN-1:0]   epc_q,
  input logic [XLEN-1:0]   badva_q,
  input logic              irq_req,
  input logic              int_enabled,
  input logic              kernel_mode
);

  p_push_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> (stk_q[STK_W-1:2] == $past(stk_q[STK_W-3:0])));

  p_push_kernel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> (kernel_mode && !int_enabled));

  p_pop_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rfe && !exc_valid) |=> ((stk_q[STK_W-3:0] == $past(stk_q[STK_W-1:2]))
                             && $stable(stk_q[STK_W-1 -: 2])));

  p_code_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> (code_q == $past(exc_code)));

  p_epc_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> (epc_q == $past(fault_pc) - XLEN'(PC_ADJ)));

  p_badva_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc_valid && is_addr_fault(exc_code)) |=> $stable(badva_q));

  p_pend_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pend_q == $past(hw_irq)));

  p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (int_enabled && (pend_q != '0)));

endmodule

bind sysctl_exc_regs sysctl_exc_regs_chk #(
  .XLEN   (XLEN),
  .NUM_HW (NUM_HW),
  .STK_W  (STK_W),
  .PC_ADJ (PC_ADJ)
) i_chk (
  .clk         (clk),
  .rst_n       (rst_n_sync),
  .exc_valid   (exc_valid),
  .exc_code    (exc_code),
  .fault_pc    (fault_pc),
  .rfe         (rfe),
  .hw_irq      (hw_irq),
  .stk_q       (stk_q),
  .pend_q      (pend_q),
  .code_q      (code_q),
  .epc_q       (epc_q),
  .badva_q     (badva_q),
  .irq_req     (irq_req),
  .int_enabled (int_enabled),
  .kernel_mode (kernel_mode)
);

// File: tb/test_sysctl_exc_regs.sv
`timescale 1ns/1ps
module test_sysctl_exc_regs;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        exc_valid;
  logic [3:0]  exc_code;
  logic [31:0] fault_pc;
  logic [31:0] fault_addr;
  logic [4:0]  hw_irq;
  logic        rfe;
  logic        reg_wr_en;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq_req;
  logic        kernel_mode;
  logic        int_enabled;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  sysctl_exc_regs i_sysctl_exc_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .exc_valid   (exc_valid),
    .exc_code    (exc_code),
    .fault_pc    (fault_pc),
    .fault_addr  (fault_addr),
    .hw_irq      (hw_irq),
    .rfe         (rfe),
    .reg_wr_en   (reg_wr_en),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .irq_req     (irq_req),
    .kernel_mode (kernel_mode),
    .int_enabled (int_enabled)
  );

  // {hw_irq[4:0], state write [15:0], expected irq_req}
  localparam logic [21:0] VEC [8] = '{
    {5'b00001, 16'h0401, 1'b1},
    {5'b00001, 16'h0400, 1'b0},
    {5'b00010, 16'h0401, 1'b0},
    {5'b00010, 16'h0801, 1'b1},
    {5'b10000, 16'h4001, 1'b1},
    {5'b10000, 16'h8301, 1'b0},
    {5'b00000, 16'hFF01, 1'b0},
    {5'b11111, 16'h7C03, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr_en = 1'b0;
  endtask

  task automatic take_exc(input logic [3:0] c, input logic [31:0] pc, input logic [31:0] ad);
    @(negedge clk);
    exc_valid = 1'b1; exc_code = c; fault_pc = pc; fault_addr = ad;
    @(posedge clk); #1;
    exc_valid = 1'b0;
  endtask

  task automatic do_rfe();
    @(negedge clk);
    rfe = 1'b1;
    @(posedge clk); #1;
    rfe = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; exc_valid = 1'b0; exc_code = '0; fault_pc = '0; fault_addr = '0;
    hw_irq = '0; rfe = 1'b0; reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0;
    #23;
    // R1 during reset
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d); chk("R1 reset reg", d, 32'h0);
    end
    chk("R1 kernel_mode", {31'b0, kernel_mode}, 32'h1);
    chk("R1 int_enabled", {31'b0, int_enabled}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk); #1;
    rd(0, d); chk("R1 state after release", d, 32'h0);
    chk("R1 irq_req", {31'b0, irq_req}, 32'h0);

    // table walk: R8, R9, R2
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      hw_irq = VEC[i][21:17];
      reg_wr_en = 1'b1; reg_addr = 2'd0; reg_wdata = {16'h0, VEC[i][16:1]};
      @(posedge clk); #1;
      reg_wr_en = 1'b0;
      chk("R9 irq_req", {31'b0, irq_req}, {31'b0, VEC[i][0]});
      rd(1, d); chk("R8 pending", d, {17'b0, VEC[i][21:17], 10'b0});
      rd(0, d); chk("R2 state readback", d, {16'h0, VEC[i][16:1]});
      chk("R11 int_enabled", {31'b0, int_enabled}, {31'b0, VEC[i][1]});
      chk("R11 kernel_mode", {31'b0, kernel_mode}, {31'b0, ~VEC[i][2]});
    end
    @(negedge clk); hw_irq = '0;

    // nested exceptions and returns
    wr(0, 32'h0000_0037);
    take_exc(4'd12, 32'h0000_1004, 32'h0000_DEAD);
    rd(0, d); chk("R3 push 1", d, 32'h0000_001C);
    chk("R3 kernel", {31'b0, kernel_mode}, 32'h1);
    chk("R3 disabled", {31'b0, int_enabled}, 32'h0);
    rd(1, d); chk("R5 code 12", d, 32'h0000_0030);
    rd(2, d); chk("R6 epc", d, 32'h0000_1000);
    rd(3, d); chk("R7 no capture on overflow", d, 32'h0);
    take_exc(4'd4, 32'h0000_2008, 32'h0BAD_0000);
    rd(0, d); chk("R3 push 2", d, 32'h0000_0030);
    rd(3, d); chk("R7 capture code 4", d, 32'h0BAD_0000);
    rd(2, d); chk("R6 epc 2", d, 32'h0000_2004);
    rd(1, d); chk("R5 code 4", d, 32'h0000_0010);
    do_rfe();
    rd(0, d); chk("R4 pop 1", d, 32'h0000_003C);
    do_rfe();
    rd(0, d); chk("R4 pop 2", d, 32'h0000_003F);
    chk("R11 user mode", {31'b0, kernel_mode}, 32'h0);
    chk("R11 enabled", {31'b0, int_enabled}, 32'h1);

    // R10 exception + return + write in one cycle
    @(negedge clk);
    exc_valid = 1'b1; exc_code = 4'd8; fault_pc = 32'h0000_3000; fault_addr = 32'h0000_1111;
    rfe = 1'b1; reg_wr_en = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h0000_FFFF;
    @(posedge clk); #1;
    exc_valid = 1'b0; rfe = 1'b0; reg_wr_en = 1'b0;
    rd(0, d); chk("R10 exception wins", d, 32'h0000_003C);
    rd(1, d); chk("R10 code 8", d, 32'h0000_0020);
    rd(2, d); chk("R10 epc", d, 32'h0000_2FFC);
    rd(3, d); chk("R7 hold on syscall", d, 32'h0BAD_0000);
    // R10 return + write
    @(negedge clk);
    rfe = 1'b1; reg_wr_en = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h0000_FF00;
    @(posedge clk); #1;
    rfe = 1'b0; reg_wr_en = 1'b0;
    rd(0, d); chk("R10 return wins", d, 32'h0000_003F);
    // R10 exception vs saved-address write
    @(negedge clk);
    exc_valid = 1'b1; exc_code = 4'd5; fault_pc = 32'h0000_4004; fault_addr = 32'h2222_0000;
    reg_wr_en = 1'b1; reg_addr = 2'd2; reg_wdata = 32'hAAAA_AAAA;
    @(posedge clk); #1;
    exc_valid = 1'b0; reg_wr_en = 1'b0;
    rd(2, d); chk("R10 epc from exception", d, 32'h0000_4000);
    rd(3, d); chk("R7 capture code 5", d, 32'h2222_0000);

    // ignored writes
    wr(1, 32'hFFFF_FFFF);
    rd(1, d); chk("R8 cause write ignored", d, 32'h0000_0014);
    wr(3, 32'h5555_5555);
    rd(3, d); chk("R7 badva write ignored", d, 32'h2222_0000);
    wr(2, 32'h1234_5678);
    rd(2, d); chk("R6 epc software write", d, 32'h1234_5678);
    wr(0, 32'hFFFF_FFFF);
    rd(0, d); chk("R2 unused bits zero", d, 32'h0000_FF3F);

    // R8 latency and release, R9 follow
    @(negedge clk); hw_irq = 5'b00100;
    rd(1, d); chk("R8 not yet sampled", d, 32'h0000_0014);
    chk("R9 no request yet", {31'b0, irq_req}, 32'h0);
    @(posedge clk); #1;
    rd(1, d); chk("R8 sampled", d, 32'h0000_1014);
    chk("R9 request", {31'b0, irq_req}, 32'h1);
    @(negedge clk); hw_irq = 5'b00000;
    @(posedge clk); #1;
    rd(1, d); chk("R8 cleared on release", d, 32'h0000_0014);
    chk("R9 request dropped", {31'b0, irq_req}, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule